// File: doc/BRIEF.md
# Signed-Coordinate Raster Timing Generator

This block turns a pixel clock into the horizontal and vertical timing of a raster display. It keeps a column counter and a row counter as 16-bit two's-complement screen coordinates. Each line and each frame opens with its blanking interval, and blanking is given negative coordinates. As a result, the first visible pixel is always at (0,0), and pixel generators downstream can use the coordinates directly as addresses.

From the counters the block decodes horizontal and vertical sync with a polarity chosen per axis, a data-enable flag for the visible area, and one-cycle strobes that mark the start of each line and each frame. Active size, porch widths, sync widths and polarities are module parameters. The defaults give the 640x480 mode, and the same design covers 800x600 (40/128/88 horizontal, 1/4/23 vertical, both polarities high), 1280x720 (110/40/220, 5/5/20, high) and 1920x1080 (88/44/148, 4/5/36, high).

Top module: `vtg_raster_timer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the counters are loaded so that after that edge sx = HS and sy = VS, where HS = -(H_FP+H_SYNC+H_BP) and VS = -(V_FP+V_SYNC+V_BP).
- R2: `sx` is a 16-bit two's-complement value. It rises by one per clock from HS to H_RES-1, and after H_RES-1 it returns to HS.
- R3: `sy` is a 16-bit two's-complement value. It rises by one in the clock where `sx` wraps from H_RES-1. At the end of line V_RES-1 it returns to VS, and otherwise it holds.
- R4: `de` is 1 exactly when sx >= 0 and sy >= 0, so the visible area runs from (0,0) to (H_RES-1, V_RES-1).
- R5: Horizontal sync is active for HS+H_FP <= sx < HS+H_FP+H_SYNC. Within blanking the order is front porch, then sync, then back porch.
- R6: Vertical sync is active for VS+V_FP <= sy < VS+V_FP+V_SYNC, for whole lines.
- R7: A polarity parameter of 1 drives the sync output high while it is active. A polarity of 0 drives it low while active and high otherwise.
- R8: `line_start` is 1 exactly in the cycles where sx = HS.
- R9: `frame_start` is 1 exactly when sx = HS and sy = VS.
- R10: With default parameters the first coordinate after reset is (-160,-45), and both syncs are active-low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pix | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| sx | output | 16 | Signed column coordinate |
| sy | output | 16 | Signed row coordinate |
| hsync | output | 1 | Horizontal sync at the configured polarity |
| vsync | output | 1 | Vertical sync at the configured polarity |
| de | output | 1 | High inside the visible area |
| line_start | output | 1 | One-cycle strobe at the first column of each line |
| frame_start | output | 1 | One-cycle strobe at the first cycle of each frame |

## Verification
The rarest event is the double wrap on the last visible pixel of the last row, where both counters return to their blanking start in the same edge. A full default frame takes more than 400,000 clocks, so the bench also builds two tiny configurations whose frames last 126 and 70 cycles. These cross the double wrap dozens of times, and the two configurations have opposite polarities. Resets placed by a seeded random draw land mid-line and mid-frame, which checks that reset recovery does not depend on where the counters were.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    localparam int COORD_W = 16;

    typedef logic signed [COORD_W-1:0] coord_t;

    typedef struct packed {
        coord_t x;
        coord_t y;
    } raster_pos_t;

    typedef struct packed {
        logic hsync;
        logic vsync;
        logic de;
        logic line_start;
        logic frame_start;
    } video_ctl_t;

    // First coordinate of an axis: blanking precedes the visible span.
    function automatic coord_t blank_start(input int fp, input int sync_w, input int bp);
        return coord_t'(-(fp + sync_w + bp));
    endfunction

    // True when v lies in [lo, lo+len), evaluated as signed integers.
    function automatic logic in_window(input coord_t v, input coord_t lo, input int len);
        return (int'(v) >= int'(lo)) && (int'(v) < int'(lo) + len);
    endfunction

endpackage

// File: rtl/vtg_axis_counter.sv
module vtg_axis_counter
    import vtg_pkg::*;
#(
    parameter int RES    = 640,
    parameter int FP     = 16,
    parameter int SYNC_W = 96,
    parameter int BP     = 48
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   step,
    output coord_t pos,
    output logic   at_end,
    output logic   at_start,
    output logic   sync_zone
);

    localparam coord_t START   = blank_start(FP, SYNC_W, BP);
    localparam coord_t LAST    = coord_t'(RES - 1);
    localparam coord_t SYNC_LO = coord_t'(int'(START) + FP);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= START;
        end else if (step) begin
            pos <= at_end ? START : pos + coord_t'(1);
        end
    end

    assign at_end    = (pos == LAST);
    assign at_start  = (pos == START);
    assign sync_zone = in_window(pos, SYNC_LO, SYNC_W);

    // R2/R3: position never leaves the span of the axis
    assert_pos_in_span_R2: assert property (@(posedge clk) disable iff (rst)
        (pos >= START) && (pos <= LAST));

    // R2/R3: last position wraps to the blanking start
    assert_wrap_to_start_R3: assert property (@(posedge clk) disable iff (rst)
        (step && at_end) |=> (pos == START));

    // R2: ordinary step advances by exactly one
    assert_step_by_one_R2: assert property (@(posedge clk) disable iff (rst)
        (step && !at_end) |=> (pos == $past(pos) + coord_t'(1)));

    // R3: without a step the position holds
    assert_hold_without_step_R3: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(pos));

endmodule

// File: rtl/vtg_ctl_decode.sv
module vtg_ctl_decode
    import vtg_pkg::*;
#(
    parameter bit H_POL = 1'b0,
    parameter bit V_POL = 1'b0
) (
    input  raster_pos_t pos,
    input  logic        h_zone,
    input  logic        v_zone,
    input  logic        h_first,
    input  logic        v_first,
    output video_ctl_t  ctl
);

    always_comb begin
        ctl.de          = !pos.x[COORD_W-1] && !pos.y[COORD_W-1];
        ctl.hsync       = H_POL ? h_zone : !h_zone;
        ctl.vsync       = V_POL ? v_zone : !v_zone;
        ctl.line_start  = h_first;
        ctl.frame_start = h_first && v_first;
    end

endmodule

// File: rtl/vtg_raster_timer.sv
module vtg_raster_timer
    import vtg_pkg::*;
#(
    parameter int H_RES  = 640,
    parameter int H_FP   = 16,
    parameter int H_SYNC = 96,
    parameter int H_BP   = 48,
    parameter int V_RES  = 480,
    parameter int V_FP   = 10,
    parameter int V_SYNC = 2,
    parameter int V_BP   = 33,
    parameter bit H_POL  = 1'b0,
    parameter bit V_POL  = 1'b0
) (
    input  logic                       clk_pix,
    input  logic                       rst,
    output logic signed [COORD_W-1:0]  sx,
    output logic signed [COORD_W-1:0]  sy,
    output logic                       hsync,
    output logic                       vsync,
    output logic                       de,
    output logic                       line_start,
    output logic                       frame_start
);

    raster_pos_t pos;
    video_ctl_t  ctl;
    logic h_end, h_first, h_zone;
    logic v_end, v_first, v_zone;

    vtg_axis_counter #(
        .RES(H_RES), .FP(H_FP), .SYNC_W(H_SYNC), .BP(H_BP)
    ) u_col (
        .clk(clk_pix), .rst(rst), .step(1'b1),
        .pos(pos.x), .at_end(h_end), .at_start(h_first), .sync_zone(h_zone)
    );

    vtg_axis_counter #(
        .RES(V_RES), .FP(V_FP), .SYNC_W(V_SYNC), .BP(V_BP)
    ) u_row (
        .clk(clk_pix), .rst(rst), .step(h_end),
        .pos(pos.y), .at_end(v_end), .at_start(v_first), .sync_zone(v_zone)
    );

    vtg_ctl_decode #(.H_POL(H_POL), .V_POL(V_POL)) u_dec (
        .pos(pos), .h_zone(h_zone), .v_zone(v_zone),
        .h_first(h_first), .v_first(v_first), .ctl(ctl)
    );

    assign sx          = pos.x;
    assign sy          = pos.y;
    assign hsync       = ctl.hsync;
    assign vsync       = ctl.vsync;
    assign de          = ctl.de;
    assign line_start  = ctl.line_start;
    assign frame_start = ctl.frame_start;

    // R4: visible pixels never coincide with an active sync
    assert_de_outside_sync_R4: assert property (@(posedge clk_pix) disable iff (rst)
        de |-> ((hsync == !H_POL) && (vsync == !V_POL)));

    // R9: a frame strobe is always also a line strobe
    assert_frame_on_line_R9: assert property (@(posedge clk_pix) disable iff (rst)
        frame_start |-> line_start);

    // R8: the line strobe lasts a single cycle
    assert_line_pulse_R8: assert property (@(posedge clk_pix) disable iff (rst)
        line_start |=> !line_start);

    // R3: the row only moves on the cycle after the column wrapped
    assert_row_moves_on_wrap_R3: assert property (@(posedge clk_pix) disable iff (rst)
        (sx != coord_t'(H_RES - 1)) |=> $stable(sy));

endmodule

// File: tb/vtg_raster_timer_bench.sv
module vtg_raster_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N_CYCLES   = 4000;
    localparam int N_UNITS    = 3;

    // unit 0: tiny, low polarity; unit 1: tiny, high polarity; unit 2: defaults
    int c_hres[N_UNITS] = '{8, 5, 640};
    int c_hfp [N_UNITS] = '{2, 1, 16};
    int c_hsw [N_UNITS] = '{3, 1, 96};
    int c_hbp [N_UNITS] = '{1, 3, 48};
    int c_vres[N_UNITS] = '{4, 3, 480};
    int c_vfp [N_UNITS] = '{1, 2, 10};
    int c_vsw [N_UNITS] = '{2, 1, 2};
    int c_vbp [N_UNITS] = '{2, 1, 33};
    int c_pol [N_UNITS] = '{0, 1, 0};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic done = 1'b0;
    int   checks = 0;
    int   failures = 0;

    logic signed [15:0] sx [N_UNITS];
    logic signed [15:0] sy [N_UNITS];
    logic hs [N_UNITS], vs [N_UNITS], de [N_UNITS], ls [N_UNITS], fs [N_UNITS];

    always #(CLK_PERIOD/2) clk = ~clk;

    vtg_raster_timer #(
        .H_RES(8), .H_FP(2), .H_SYNC(3), .H_BP(1),
        .V_RES(4), .V_FP(1), .V_SYNC(2), .V_BP(2),
        .H_POL(1'b0), .V_POL(1'b0)
    ) u_vtg_raster_timer (
        .clk_pix(clk), .rst(rst), .sx(sx[0]), .sy(sy[0]), .hsync(hs[0]),
        .vsync(vs[0]), .de(de[0]), .line_start(ls[0]), .frame_start(fs[0])
    );

    vtg_raster_timer #(
        .H_RES(5), .H_FP(1), .H_SYNC(1), .H_BP(3),
        .V_RES(3), .V_FP(2), .V_SYNC(1), .V_BP(1),
        .H_POL(1'b1), .V_POL(1'b1)
    ) u_vtg_raster_timer_pos (
        .clk_pix(clk), .rst(rst), .sx(sx[1]), .sy(sy[1]), .hsync(hs[1]),
        .vsync(vs[1]), .de(de[1]), .line_start(ls[1]), .frame_start(fs[1])
    );

    vtg_raster_timer u_vtg_raster_timer_dflt (
        .clk_pix(clk), .rst(rst), .sx(sx[2]), .sy(sy[2]), .hsync(hs[2]),
        .vsync(vs[2]), .de(de[2]), .line_start(ls[2]), .frame_start(fs[2])
    );

    function automatic int hstart(int u);
        return -(c_hfp[u] + c_hsw[u] + c_hbp[u]);
    endfunction

    function automatic int vstart(int u);
        return -(c_vfp[u] + c_vsw[u] + c_vbp[u]);
    endfunction

    function automatic int exp_sync(int p, int st, int fp, int w, int pol);
        logic act;
        act = (p >= st + fp) && (p < st + fp + w);
        return pol != 0 ? int'(act) : int'(!act);
    endfunction

    // reference coordinates
    int  mx [N_UNITS];
    int  my [N_UNITS];
    logic last_rst = 1'b0;

    always @(posedge clk) begin
        last_rst <= rst;
        for (int u = 0; u < N_UNITS; u++) begin
            if (rst) begin
                mx[u] <= hstart(u);
                my[u] <= vstart(u);
            end else if (mx[u] == c_hres[u] - 1) begin
                mx[u] <= hstart(u);
                my[u] <= (my[u] == c_vres[u] - 1) ? vstart(u) : my[u] + 1;
            end else begin
                mx[u] <= mx[u] + 1;
            end
        end
    end

    task automatic chk(string req, int u, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s unit%0d %s actual=%0d expected=%0d @%0t", req, u, what, act, exp, $time);
        end
    endtask

    task automatic check_unit(int u);
        int ex, ey;
        ex = mx[u];
        ey = my[u];
        if (last_rst) begin
            chk("R1", u, "sx after reset", int'(sx[u]), hstart(u));
            chk("R1", u, "sy after reset", int'(sy[u]), vstart(u));
        end
        chk("R2", u, "sx", int'(sx[u]), ex);
        chk("R3", u, "sy", int'(sy[u]), ey);
        chk("R4", u, "de", int'(de[u]), int'(ex >= 0 && ey >= 0));
        chk("R5_R7", u, "hsync", int'(hs[u]), exp_sync(ex, hstart(u), c_hfp[u], c_hsw[u], c_pol[u]));
        chk("R6_R7", u, "vsync", int'(vs[u]), exp_sync(ey, vstart(u), c_vfp[u], c_vsw[u], c_pol[u]));
        chk("R8", u, "line_start", int'(ls[u]), int'(ex == hstart(u)));
        chk("R9", u, "frame_start", int'(fs[u]), int'(ex == hstart(u) && ey == vstart(u)));
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0017);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R10: default mode opens at (-160,-45) with low-active syncs idle high
        chk("R10", 2, "default sx", int'(sx[2]), -160);
        chk("R10", 2, "default sy", int'(sy[2]), -45);
        chk("R10", 2, "default hsync idle", int'(hs[2]), 1);
        chk("R10", 2, "default vsync idle", int'(vs[2]), 1);
        rst = 1'b0;
        for (int cyc = 0; cyc < N_CYCLES; cyc++) begin
            @(negedge clk);
            for (int u = 0; u < N_UNITS; u++) check_unit(u);
            // R1: occasional resets at random points, one longer burst
            if (cyc == 2500) rst = 1'b1;
            else if (cyc == 2503) rst = 1'b0;
            else rst = (($urandom % 300) == 0);
        end
        // R10: default sync goes low once x reaches -144 (16 columns of front porch)
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (16) @(negedge clk);
        chk("R10", 2, "default sx at sync", int'(sx[2]), -144);
        chk("R10", 2, "default hsync active low", int'(hs[2]), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule